// File: doc/BRIEF.md
# Branch Hazard Control Unit

This block steers instruction fetch around conditional branches in a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) whose branches are only resolved once they reach the memory stage. It owns the fetch program counter. Each cycle it picks the next fetch address and tells the pipeline which stage registers to clear to bubbles, so that wrong-path instructions never alter machine state.

Decode reports whether its instruction is a branch, together with the branch's static hint bit, the sign of its offset and its computed target. The memory stage reports the real outcome and target. The unit keeps its own record of each branch as it moves from decode through execute to memory. It also remembers which fetch slots it has squashed, so a branch that arrives in decode as a squashed instruction is ignored.

A two-bit policy input chooses one of four ways to handle branches: freeze, predict-not-taken, static prediction, or an architectural delay slot. A build parameter sets the source of the static prediction: either the hint bit or the offset sign.

Top module: `branch_hazard_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `pc` equals `RESET_PC` and `flush_if`, `flush_id`, `flush_ex`, `fetch_hold` and `err_ds` are all low.
- R2: When no branch is in flight, `pc` advances by `INSTR_BYTES` every cycle and `pc_sel` reads 0 (sequential). The encodings of `pc_sel` are: 0 sequential, 1 hold, 2 predicted target, 3 resolved target, 4 fall-through.
- R3: Under policy 0 (freeze), a branch fetched at address B in cycle c causes `fetch_hold` and `flush_if` to be high in cycles c+1 to c+3, and `pc` stays at B+4 during that time. In cycle c+4, `pc` is the target if the branch was taken and B+4 if it was not, which is a cost of three cycles.
- R4: Under policy 1 (predict-not-taken), fetch goes on sequentially. If the branch turns out taken, `flush_if`, `flush_id` and `flush_ex` are high in cycle c+3 and `pc` equals the target in c+4. If it is not taken, no flush occurs and fetch never pauses.
- R5: Under policy 2 (static) with the hint bit selected, a hint of 1 predicts taken: `flush_if` is high in c+1 and `pc` equals the decode target in c+2. A hint of 0 behaves exactly as in R4.
- R6: When built with `USE_DIR_HEUR`=1, policy 2 predicts taken when the offset is negative (backward branch) and not taken when it is positive, whatever the hint bit says.
- R7: When a branch predicted taken turns out not taken, all three flushes are high in c+3 and `pc` equals B+4 in c+4.
- R8: Under policy 3 (delay slot), the instruction at B+4 is fetched and kept. `fetch_hold` and `flush_if` are high in c+2 and c+3. In c+4, `pc` is the target if the branch was taken and B+8 if it was not.
- R9: Under policy 3, a branch found in the delay slot raises `err_ds` in the cycle it sits in decode. It is otherwise ignored and does not change the fetch trace.
- R10: A branch among squashed instructions never redirects fetch or raises a flush: a second branch at B+4 leaves the trace of R3 to R8 unchanged.
- R11: The policy may be switched while no branch is in flight, and the new policy governs the next branch. It is held stable while a branch is being tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Branch policy: 0 freeze, 1 not-taken, 2 static, 3 delay slot |
| id_is_br | input | 1 | Instruction in decode is a conditional branch |
| id_hint | input | 1 | Static prediction bit of that branch (1 = taken) |
| id_off_neg | input | 1 | Branch offset is negative |
| id_target | input | PC_W | Target computed in decode |
| mem_taken | input | 1 | Resolved outcome of the branch in the memory stage |
| mem_target | input | PC_W | Resolved target of the branch in the memory stage |
| pc | output | PC_W | Current fetch address |
| pc_sel | output | 3 | Source of the next fetch address |
| flush_if | output | 1 | Turn the fetch-to-decode register into a bubble |
| flush_id | output | 1 | Turn the decode-to-execute register into a bubble |
| flush_ex | output | 1 | Turn the execute-to-memory register into a bubble |
| fetch_hold | output | 1 | Fetch is waiting for a branch to resolve |
| err_ds | output | 1 | Illegal branch in a delay slot |

## Verification
The bench builds two copies of the unit with a 16-bit address and 4-byte instructions. One copy takes its static prediction from the hint bit, the other from the offset sign. A 16-bit address keeps forward and backward targets small enough that every expected trace can be computed by simple arithmetic.

With both copies running side by side, the bench sweeps all four policies against every combination of outcome, hint, offset sign and an optional second branch in the slot after the first. Each combination checks the fetch trace and the flush and hold pattern cycle by cycle, including mispredictions in both directions and illegal delay-slot branches.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

    typedef enum logic [1:0] {
        POL_FREEZE   = 2'd0,
        POL_NOTTAKEN = 2'd1,
        POL_STATIC   = 2'd2,
        POL_SLOT     = 2'd3
    } policy_e;

    typedef enum logic [2:0] {
        NPC_SEQ    = 3'd0,
        NPC_HOLD   = 3'd1,
        NPC_PRED   = 3'd2,
        NPC_TARGET = 3'd3,
        NPC_FALL   = 3'd4
    } npc_sel_e;

endpackage

// File: rtl/bhc_predict.sv
module bhc_predict #(
    parameter bit USE_DIR_HEUR = 1'b0
) (
    input  logic hint,
    input  logic off_neg,
    output logic pred_taken
);
    // Static direction: either the encoded bit or the backward-taken rule.
    assign pred_taken = USE_DIR_HEUR ? off_neg : hint;
endmodule

// File: rtl/bhc_resolve.sv
module bhc_resolve
    import bhc_pkg::*;
(
    input  policy_e policy,
    input  logic    rec_valid,
    input  logic    rec_pred,
    input  logic    taken,
    output logic    redirect,
    output logic    squash,
    output logic    to_target
);
    logic waiting_policy;

    always_comb begin
        waiting_policy = (policy == POL_FREEZE) || (policy == POL_SLOT);
        to_target      = taken;
        if (waiting_policy) begin
            // Fetch has been parked; resolution always sets the address.
            redirect = rec_valid;
            squash   = 1'b0;
        end else begin
            redirect = rec_valid && (taken != rec_pred);
            squash   = redirect;
        end
    end
endmodule

// File: rtl/branch_hazard_ctrl.sv
module branch_hazard_ctrl
    import bhc_pkg::*;
#(
    parameter int              PC_W         = 32,
    parameter int              INSTR_BYTES  = 4,
    parameter bit              USE_DIR_HEUR = 1'b0,
    parameter logic [PC_W-1:0] RESET_PC     = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode,
    input  logic            id_is_br,
    input  logic            id_hint,
    input  logic            id_off_neg,
    input  logic [PC_W-1:0] id_target,
    input  logic            mem_taken,
    input  logic [PC_W-1:0] mem_target,
    output logic [PC_W-1:0] pc,
    output logic [2:0]      pc_sel,
    output logic            flush_if,
    output logic            flush_id,
    output logic            flush_ex,
    output logic            fetch_hold,
    output logic            err_ds
);
    localparam logic [PC_W-1:0] STEP1 = PC_W'(INSTR_BYTES);
    localparam logic [PC_W-1:0] STEP2 = PC_W'(2 * INSTR_BYTES);

    typedef struct packed {
        logic            valid;
        logic            pred;
        logic [PC_W-1:0] fall;
    } br_rec_t;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] id_pc;
        logic            id_kill;
        br_rec_t         ex;
        br_rec_t         mem;
    } state_t;

    state_t   s_q, s_d;
    policy_e  policy;
    npc_sel_e sel;
    logic     pred_bit;
    logic     res_redirect, res_squash, res_to_target;
    logic     id_br, illegal, accept, pred_jump, parked;

    assign policy = policy_e'(mode);

    bhc_predict #(.USE_DIR_HEUR(USE_DIR_HEUR)) u_pred (
        .hint       (id_hint),
        .off_neg    (id_off_neg),
        .pred_taken (pred_bit)
    );

    bhc_resolve u_res (
        .policy    (policy),
        .rec_valid (s_q.mem.valid),
        .rec_pred  (s_q.mem.pred),
        .taken     (mem_taken),
        .redirect  (res_redirect),
        .squash    (res_squash),
        .to_target (res_to_target)
    );

    always_comb begin
        s_d = s_q;

        // A decode slot that was squashed on entry carries no branch.
        id_br   = id_is_br && !s_q.id_kill;
        illegal = (policy == POL_SLOT) && id_br && s_q.ex.valid;
        accept  = id_br && !illegal && !res_squash;
        pred_jump = (policy == POL_STATIC) && accept && pred_bit;
        parked  = ((policy == POL_FREEZE) && (id_br || s_q.ex.valid || s_q.mem.valid))
               || ((policy == POL_SLOT) && (s_q.ex.valid || s_q.mem.valid));

        sel      = NPC_SEQ;
        s_d.pc   = s_q.pc + STEP1;
        if (res_redirect) begin
            sel    = res_to_target ? NPC_TARGET : NPC_FALL;
            s_d.pc = res_to_target ? mem_target : s_q.mem.fall;
        end else if (parked) begin
            sel    = NPC_HOLD;
            s_d.pc = s_q.pc;
        end else if (pred_jump) begin
            sel    = NPC_PRED;
            s_d.pc = id_target;
        end

        flush_if   = res_redirect || parked || pred_jump;
        flush_id   = res_squash;
        flush_ex   = res_squash;
        fetch_hold = parked;
        err_ds     = illegal;

        s_d.id_pc   = s_q.pc;
        s_d.id_kill = flush_if;

        s_d.ex.valid = accept;
        s_d.ex.pred  = (policy == POL_STATIC) && pred_bit;
        s_d.ex.fall  = s_q.id_pc + ((policy == POL_SLOT) ? STEP2 : STEP1);

        s_d.mem = res_squash ? '0 : s_q.ex;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.pc <= RESET_PC;
        end else begin
            s_q <= s_d;
        end
    end

    assign pc     = s_q.pc;
    assign pc_sel = sel;

    // R3: while a frozen branch sits in execute, fetch does not move.
    a_r3_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POL_FREEZE && s_q.ex.valid) |=> $stable(pc));

    // R4: a squash for a taken branch lands on the resolved target.
    a_r4_taken_target: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_ex && mem_taken) |=> (pc == $past(mem_target)));

    // R7: a squash for an untaken branch returns to its fall-through.
    a_r7_fall_back: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_ex && !mem_taken) |=> (pc == $past(s_q.mem.fall)));

    // R8: the slot after a fresh branch is fetched sequentially.
    a_r8_slot_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POL_SLOT && id_is_br && !s_q.id_kill && !s_q.ex.valid && !s_q.mem.valid)
        |=> (pc == $past(s_q.pc) + STEP1));

    // R9: an illegal slot branch is never tracked.
    a_r9_err_untracked: assert property (@(posedge clk) disable iff (!rst_n)
        err_ds |=> !s_q.ex.valid);

    // R10: squashed stages leave no live branch record behind.
    a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush_id |=> (!s_q.ex.valid && !s_q.mem.valid));

    // R11: policy stays fixed while a branch is in flight.
    a_r11_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ex.valid || s_q.mem.valid) |-> $stable(mode));

endmodule

// File: tb/tb_branch_hazard_ctrl.sv
`timescale 1ns/1ps
module tb_branch_hazard_ctrl;
    localparam int PW = 16;
    localparam int BA = 16'h0010;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          hint = 1'b0, neg = 1'b0, taken = 1'b0, extra = 1'b0;
    logic [PW-1:0] tgt;
    logic [PW-1:0] id_addr = '0, id_addr_h = '0;
    logic          br_a, br_h;
    logic [PW-1:0] pc_a, pc_h;
    logic [2:0]    sel_a, sel_h;
    logic          fif, fid, fex, hold, err;
    logic          fif_h, fid_h, fex_h, hold_h, err_h;
    int            total = 0, bad = 0;
    bit            done = 0;

    always #2 clk = ~clk;

    assign tgt  = neg ? 16'h0000 : 16'h0080;
    assign br_a = (id_addr == PW'(BA)) || (extra && id_addr == PW'(BA + 4));
    assign br_h = (id_addr_h == PW'(BA)) || (extra && id_addr_h == PW'(BA + 4));

    // Fetch-to-decode register model: decode sees last cycle's fetch address.
    always_ff @(posedge clk) begin
        id_addr   <= pc_a;
        id_addr_h <= pc_h;
    end

    branch_hazard_ctrl #(.PC_W(PW), .INSTR_BYTES(4), .USE_DIR_HEUR(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .id_is_br(br_a), .id_hint(hint),
        .id_off_neg(neg), .id_target(tgt), .mem_taken(taken), .mem_target(tgt),
        .pc(pc_a), .pc_sel(sel_a), .flush_if(fif), .flush_id(fid), .flush_ex(fex),
        .fetch_hold(hold), .err_ds(err));

    branch_hazard_ctrl #(.PC_W(PW), .INSTR_BYTES(4), .USE_DIR_HEUR(1'b1)) dut_heur (
        .clk(clk), .rst_n(rst_n), .mode(mode), .id_is_br(br_h), .id_hint(hint),
        .id_off_neg(neg), .id_target(tgt), .mem_taken(taken), .mem_target(tgt),
        .pc(pc_h), .pc_sel(sel_h), .flush_if(fif_h), .flush_id(fid_h), .flush_ex(fex_h),
        .fetch_hold(hold_h), .err_ds(err_h));

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_pc(int m, bit p, bit tk, int t, int k);
        int r;
        case (m)
            0: r = (k <= 3) ? BA + 4 : ((tk ? t : BA + 4) + 4 * (k - 4));
            1: r = (k >= 4 && tk) ? t + 4 * (k - 4) : BA + 4 * k;
            2: begin
                if (!p)          r = (k >= 4 && tk) ? t + 4 * (k - 4) : BA + 4 * k;
                else if (k == 1) r = BA + 4;
                else if (k <= 3 || tk) r = t + 4 * (k - 2);
                else             r = BA + 4 + 4 * (k - 4);
            end
            default: r = (k <= 2) ? BA + 4 * k : (k == 3) ? BA + 8 :
                         ((tk ? t : BA + 8) + 4 * (k - 4));
        endcase
        return r;
    endfunction

    function automatic string tag_of(int m, bit p, bit tk, bit ex, bit heur);
        if (ex)              return "R10";
        if (m == 0)          return "R3";
        if (m == 1)          return "R4";
        if (m == 3)          return "R8";
        if (p && !tk)        return "R7";
        return heur ? "R6" : "R5";
    endfunction

    task automatic run(input int m, input bit tk, input bit h, input bit n, input bit ex);
        bit pa, ph, mis;
        int t, guard;
        string ta, th;
        @(negedge clk);
        rst_n = 1'b0;
        taken = tk; hint = h; neg = n; extra = ex;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mode  = 2'(m);              // switched with nothing in flight (R11)
        t  = n ? 0 : 16'h0080;
        pa = (m == 2) && h;
        ph = (m == 2) && n;
        ta = tag_of(m, pa, tk, ex, 1'b0);
        th = tag_of(m, ph, tk, ex, 1'b1);
        guard = 0;
        while (int'(pc_a) != BA && guard < 20) begin
            chk("R2 pc", int'(pc_a), 4 * guard);
            chk("R2 sel", int'(sel_a), 0);
            @(negedge clk);
            guard++;
        end
        for (int k = 1; k <= (ex ? 5 : 6); k++) begin
            @(negedge clk);
            chk($sformatf("%s pc m%0d k%0d", ta, m, k), int'(pc_a), exp_pc(m, pa, tk, t, k));
            chk($sformatf("%s pc heur m%0d k%0d", th, m, k), int'(pc_h), exp_pc(m, ph, tk, t, k));
            if (k <= 4) begin
                mis = (k == 3) && ((m == 1 && tk) || (m == 2 && tk != pa));
                chk($sformatf("%s flush_if k%0d", ta, k), int'(fif),
                    int'((m == 0 && k <= 3) || (m == 3 && (k == 2 || k == 3)) ||
                         (m == 2 && pa && k == 1) || mis));
                chk($sformatf("%s flush_id k%0d", ta, k), int'(fid), int'(mis));
                chk($sformatf("%s flush_ex k%0d", ta, k), int'(fex), int'(mis));
                chk($sformatf("%s hold k%0d", ta, k), int'(hold),
                    int'((m == 0 && k <= 3) || (m == 3 && (k == 2 || k == 3))));
                chk($sformatf("R9 err m%0d k%0d", m, k), int'(err), int'(m == 3 && ex && k == 2));
                if (k == 1) chk("R11 new policy", int'(hold), int'(m == 0));
            end
        end
    endtask

    initial begin
        #6;
        chk("R1 pc", int'(pc_a), 0);
        chk("R1 flags", int'({fif, fid, fex, hold, err}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pc after release", int'(pc_a), 4);
        for (int m = 0; m < 4; m++)
            for (int tk = 0; tk < 2; tk++)
                for (int h = 0; h < 2; h++)
                    for (int n = 0; n < 2; n++)
                        for (int ex = 0; ex < 2; ex++)
                            run(m, 1'(tk), 1'(h), 1'(n), 1'(ex));
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end
endmodule